// File: doc/BRIEF.md
# Debounced Matrix Keypad Scanner

This block reads a 4x4 key matrix. It pulls one column line low at a time and moves to the next column at a fixed scan tick. On each tick it samples the four row lines, which are active low and have pull-ups. A key is reported only after a fixed sequence. First the whole matrix must be seen clear for a full sweep. Then the scanner waits a debounce interval and sweeps again to confirm the release. Only then does it watch for a keystroke. When one appears, it waits the debounce interval once more and rescans to confirm the press. A press that has gone by the time of that rescan counts as a glitch, and the scanner goes back to watching for a keystroke.

A confirmed key is presented as a 4-bit code together with a valid strobe that lasts one clock. The code stays on its output until the next accepted key. After a report the scanner again requires a full release, so a held key is reported once. If several keys are down, the scanner reports only the first one it meets. The debounce interval and the scan tick are both counts of clock cycles, set by parameters.

Top module: `keypad_scanner`

## Requirements
- R1: During and after reset, the column output is 4'b1110 (column 0 driven low), the valid output is 0 and the key code is 0.
- R2: Exactly one column line is low at any time. The low line moves after every SCAN_TICK_CYCLES clocks, in the order 0,1,2,3,0; in active-low terms, each new value is the old one rotated left by one bit.
- R3: The key at row r (row_n_i[r]) and column c (col_n_o[c]) is reported with code r*4 + c.
- R4: The valid output is high for exactly one clock for each accepted key. The key code changes only together with a valid pulse and otherwise holds its last value.
- R5: The valid pulse for a press does not come sooner than DEBOUNCE_CYCLES clocks after the key closes. It comes no later than DEBOUNCE_CYCLES + 8*SCAN_TICK_CYCLES + 4 clocks after the key closes, provided the matrix was already confirmed released.
- R6: A closure that has ended before the confirming rescan produces no valid pulse and leaves the code unchanged. A valid press that follows is still reported.
- R7: A key held after it has been reported gives no further valid pulse until all keys are released and the release is confirmed.
- R8: When several rows close in the same column, the lowest row index is reported. A valid pulse is only ever produced right after a clock edge at which some row line was sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| row_n_i | input | 4 | Row sense lines, low where a key in the driven column is closed |
| col_n_o | output | 4 | Column drive lines, one low at a time |
| key_code_o | output | 4 | Code of the last accepted key, row*4 + column |
| key_valid_o | output | 1 | One-clock strobe that marks a newly accepted key |

## Verification
The bench scales the scanner down to a tick of 4 clocks and a debounce interval of 40 clocks, so one full sweep takes 16 clocks. Each press starts only after 120 idle clocks, which covers the longest possible release confirmation. After a press the bench counts clocks until valid rises. It checks that this count is above 40 and no more than 76, which covers one sweep to detect, the debounce interval, one sweep to confirm, and the register stages in between. Every sample is taken on the falling clock edge, half a cycle after the registers update. The one-clock width of the strobe is checked on the following falling edge. Glitch and hold cases are watched over windows longer than a full detect, debounce and confirm cycle.

// File: rtl/keypad_scan_pkg.sv
package keypad_scan_pkg;
    typedef enum logic [2:0] {
        ST_REL_SCAN,
        ST_REL_WAIT,
        ST_REL_CHK,
        ST_PRS_SCAN,
        ST_PRS_WAIT,
        ST_PRS_CHK,
        ST_REPORT
    } scan_state_e;
endpackage

// File: rtl/kp_column_driver.sv
module kp_column_driver #(
    parameter int COLS             = 4,
    parameter int SCAN_TICK_CYCLES = 1000,
    localparam int CW = (COLS > 1) ? $clog2(COLS) : 1,
    localparam int TW = (SCAN_TICK_CYCLES > 1) ? $clog2(SCAN_TICK_CYCLES) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          tick_o,
    output logic [CW-1:0] col_idx_o,
    output logic [COLS-1:0] col_n_o
);
    logic [TW-1:0] tick_cnt_d, tick_cnt_q;
    logic [CW-1:0] col_idx_d, col_idx_q;

    assign tick_o = (tick_cnt_q == TW'(SCAN_TICK_CYCLES - 1));

    always_comb begin
        tick_cnt_d = tick_o ? '0 : tick_cnt_q + 1'b1;
        col_idx_d  = col_idx_q;
        if (tick_o) begin
            col_idx_d = (col_idx_q == CW'(COLS - 1)) ? '0 : col_idx_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_cnt_q <= '0;
            col_idx_q  <= '0;
        end else begin
            tick_cnt_q <= tick_cnt_d;
            col_idx_q  <= col_idx_d;
        end
    end

    assign col_idx_o = col_idx_q;

    for (genvar g = 0; g < COLS; g++) begin : g_col
        assign col_n_o[g] = (col_idx_q != CW'(g));
    end
endmodule

// File: rtl/kp_row_encoder.sv
module kp_row_encoder #(
    parameter int ROWS = 4,
    localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic [ROWS-1:0] row_n_i,
    output logic            hit_o,
    output logic [RW-1:0]   row_idx_o
);
    always_comb begin
        hit_o     = 1'b0;
        row_idx_o = '0;
        for (int i = ROWS - 1; i >= 0; i--) begin
            if (!row_n_i[i]) begin
                hit_o     = 1'b1;
                row_idx_o = RW'(i);
            end
        end
    end
endmodule

// File: rtl/kp_debounce_timer.sv
module kp_debounce_timer #(
    parameter int DEBOUNCE_CYCLES = 2_000_000,
    localparam int DW = $clog2(DEBOUNCE_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic done_o
);
    logic [DW-1:0] cnt_d, cnt_q;

    assign done_o = run_i && (cnt_q == DW'(DEBOUNCE_CYCLES - 1));

    always_comb begin
        if (!run_i)      cnt_d = '0;
        else if (done_o) cnt_d = cnt_q;
        else             cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/keypad_scanner.sv
module keypad_scanner #(
    parameter int ROWS             = 4,
    parameter int COLS             = 4,
    parameter int SCAN_TICK_CYCLES = 1000,
    parameter int DEBOUNCE_CYCLES  = 2_000_000,
    localparam int RW  = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int CW  = (COLS > 1) ? $clog2(COLS) : 1,
    localparam int KW  = $clog2(ROWS * COLS),
    localparam int CLW = $clog2(COLS + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ROWS-1:0] row_n_i,
    output logic [COLS-1:0] col_n_o,
    output logic [KW-1:0]   key_code_o,
    output logic            key_valid_o
);
    import keypad_scan_pkg::*;

    typedef struct packed {
        scan_state_e    state;
        logic [CLW-1:0] clean;
        logic [KW-1:0]  code;
    } scan_regs_t;

    scan_regs_t r_d, r_q;

    logic          tick;
    logic [CW-1:0] col_idx;
    logic          hit;
    logic [RW-1:0] row_idx;
    logic          db_run, db_done;
    logic          sweep_clean;

    kp_column_driver #(.COLS(COLS), .SCAN_TICK_CYCLES(SCAN_TICK_CYCLES)) u_cols (
        .clk(clk), .rst_n(rst_n), .tick_o(tick), .col_idx_o(col_idx), .col_n_o(col_n_o)
    );

    kp_row_encoder #(.ROWS(ROWS)) u_rows (
        .row_n_i(row_n_i), .hit_o(hit), .row_idx_o(row_idx)
    );

    assign db_run = (r_q.state == ST_REL_WAIT) || (r_q.state == ST_PRS_WAIT);

    kp_debounce_timer #(.DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)) u_db (
        .clk(clk), .rst_n(rst_n), .run_i(db_run), .done_o(db_done)
    );

    // a full sweep without any closure ends on this tick
    assign sweep_clean = (r_q.clean == CLW'(COLS - 1));

    always_comb begin
        r_d = r_q;
        case (r_q.state)
            ST_REL_SCAN: if (tick) begin
                if (hit) r_d.clean = '0;
                else if (sweep_clean) begin
                    r_d.state = ST_REL_WAIT;
                    r_d.clean = '0;
                end else r_d.clean = r_q.clean + 1'b1;
            end
            ST_REL_WAIT: if (db_done) begin
                r_d.state = ST_REL_CHK;
                r_d.clean = '0;
            end
            ST_REL_CHK: if (tick) begin
                if (hit) begin
                    r_d.state = ST_REL_SCAN;
                    r_d.clean = '0;
                end else if (sweep_clean) begin
                    r_d.state = ST_PRS_SCAN;
                    r_d.clean = '0;
                end else r_d.clean = r_q.clean + 1'b1;
            end
            ST_PRS_SCAN: if (tick && hit) r_d.state = ST_PRS_WAIT;
            ST_PRS_WAIT: if (db_done) begin
                r_d.state = ST_PRS_CHK;
                r_d.clean = '0;
            end
            ST_PRS_CHK: if (tick) begin
                if (hit) begin
                    r_d.state = ST_REPORT;
                    r_d.code  = KW'(row_idx) * KW'(COLS) + KW'(col_idx);
                end else if (sweep_clean) begin
                    r_d.state = ST_PRS_SCAN;
                    r_d.clean = '0;
                end else r_d.clean = r_q.clean + 1'b1;
            end
            ST_REPORT: begin
                r_d.state = ST_REL_SCAN;
                r_d.clean = '0;
            end
            default: begin
                r_d.state = ST_REL_SCAN;
                r_d.clean = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_REL_SCAN;
            r_q.clean <= '0;
            r_q.code  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign key_valid_o = (r_q.state == ST_REPORT);
    assign key_code_o  = r_q.code;
endmodule

// File: rtl/keypad_scanner_checker.sv
module keypad_scanner_checker #(
    parameter int ROWS = 4,
    parameter int COLS = 4,
    parameter int KW   = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic [ROWS-1:0] row_n_i,
    input logic [COLS-1:0] col_n_o,
    input logic [KW-1:0]   key_code_o,
    input logic            key_valid_o
);
    always_comb begin
        if (!rst_n) begin
            assert_reset_cols_R1: assert (col_n_o == {{(COLS-1){1'b1}}, 1'b0});
            assert_reset_valid_R1: assert (!key_valid_o);
        end
    end

    assert_one_col_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~col_n_o) == 1);

    assert_col_rotate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(col_n_o) |-> col_n_o == {$past(col_n_o[COLS-2:0]), $past(col_n_o[COLS-1])});

    assert_valid_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid_o |=> !key_valid_o);

    assert_code_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(key_code_o) |-> key_valid_o);

    assert_valid_after_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(key_valid_o) |-> !(&$past(row_n_i)));
endmodule

bind keypad_scanner keypad_scanner_checker #(.ROWS(ROWS), .COLS(COLS), .KW(KW)) u_chk (
    .clk(clk), .rst_n(rst_n), .row_n_i(row_n_i), .col_n_o(col_n_o),
    .key_code_o(key_code_o), .key_valid_o(key_valid_o)
);

// File: tb/keypad_scanner_bench.sv
module keypad_scanner_bench;
    localparam int TICK  = 4;
    localparam int DB    = 40;
    localparam int SWEEP = 4 * TICK;
    localparam int LAT_MAX = DB + 2 * SWEEP + 4;

    // each entry: row[7:6], column[5:4], expected code[3:0]
    localparam logic [7:0] VEC [6] = '{
        {2'd0, 2'd0, 4'd0},  {2'd1, 2'd2, 4'd6},  {2'd3, 2'd3, 4'd15},
        {2'd2, 2'd1, 4'd9},  {2'd0, 2'd3, 4'd3},  {2'd3, 2'd0, 4'd12}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] row_n;
    logic [3:0] col_n;
    logic [3:0] code;
    logic       valid;
    logic [15:0] keys = '0;
    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    keypad_scanner #(.SCAN_TICK_CYCLES(TICK), .DEBOUNCE_CYCLES(DB)) u_keypad_scanner (
        .clk(clk), .rst_n(rst_n), .row_n_i(row_n), .col_n_o(col_n),
        .key_code_o(code), .key_valid_o(valid)
    );

    always_comb begin
        for (int r = 0; r < 4; r++) begin
            row_n[r] = 1'b1;
            for (int c = 0; c < 4; c++)
                if (keys[r*4+c] && !col_n[c]) row_n[r] = 1'b0;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++; total++;
            $display("FAIL watchdog: act=%0d exp<=150000 cycles", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic wait_valid(input int limit, output int lat);
        lat = 0;
        while (!valid && lat < limit) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic count_valid(input int n, output int pulses);
        pulses = 0;
        repeat (n) begin
            @(negedge clk);
            if (valid) pulses++;
        end
    endtask

    task automatic press_and_check(input int mask, input int exp_code, input string req);
        int lat;
        keys = 16'(mask);
        wait_valid(LAT_MAX + 20, lat);
        chk(valid, "R5 valid seen", int'(valid), 1);
        chk(lat > DB, "R5 not before debounce", lat, DB + 1);
        chk(lat <= LAT_MAX, "R5 latency bound", lat, LAT_MAX);
        chk(code == 4'(exp_code), req, int'(code), exp_code);
        @(negedge clk);
        chk(!valid, "R4 one-cycle strobe", int'(valid), 0);
    endtask

    initial begin
        int pulses;
        logic [3:0] prev;
        int changes;
        repeat (3) @(negedge clk);
        chk(col_n == 4'b1110, "R1 columns in reset", int'(col_n), 14);
        chk(!valid, "R1 valid in reset", int'(valid), 0);
        chk(code == 4'd0, "R1 code in reset", int'(code), 0);
        rst_n = 1'b1;

        // R2: rotation over 40 clocks
        prev = col_n;
        changes = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if ($countones(~col_n) != 1)
                chk(1'b0, "R2 one column low", int'(col_n), 0);
            if (col_n != prev) begin
                changes++;
                chk(col_n == {prev[2:0], prev[3]}, "R2 rotation order",
                    int'(col_n), int'({prev[2:0], prev[3]}));
            end
            prev = col_n;
        end
        chk(changes == 40 / TICK, "R2 step rate", changes, 40 / TICK);

        // table of single keys: R3 code, R5 timing, R7 held key
        for (int v = 0; v < 6; v++) begin
            keys = '0;
            repeat (120) @(negedge clk);
            press_and_check(1 << (int'(VEC[v][7:6]) * 4 + int'(VEC[v][5:4])),
                            int'(VEC[v][3:0]), "R3 key code");
            count_valid(150, pulses);
            chk(pulses == 0, "R7 held key reported once", pulses, 0);
        end

        // R6: short closure rejected, code held
        keys = '0;
        repeat (120) @(negedge clk);
        prev = code;
        keys = 16'(1 << 5);
        repeat (20) @(negedge clk);
        keys = '0;
        count_valid(200, pulses);
        chk(pulses == 0, "R6 glitch rejected", pulses, 0);
        chk(code == prev, "R6 code unchanged after glitch", int'(code), int'(prev));
        press_and_check(1 << 5, 5, "R6 press after glitch");

        // R8: two rows in column 2, lowest row wins
        keys = '0;
        repeat (120) @(negedge clk);
        press_and_check((1 << 6) | (1 << 14), 6, "R8 lowest row wins");

        // R7: new key only after release
        keys = '0;
        repeat (120) @(negedge clk);
        press_and_check(1 << 10, 10, "R7 press after release");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule